// File: doc/BRIEF.md
# Multi-hart core-local timer interruptor

This block gives each hart of a small multi-hart processor two interrupt sources: a software-interrupt flag that any agent on the register port can set or clear, and a timer interrupt that fires when a shared 64-bit time counter catches up with the hart's own 64-bit compare value. The time counter advances by one on every cycle in which a timebase tick-enable input is high. Software reads it through two 32-bit words and cannot write it.

All state is reached through one 32-bit register port. A request is one cycle with an enable, a write flag, an address and write data. Read data appears in the cycle after the request. The register space has three regions, each with its own base offset given as a parameter. The software-interrupt flags sit at a stride of 4 bytes, the compare registers at a stride of 8 bytes, and the time counter uses two consecutive words. A 64-bit compare register is written one 32-bit half at a time. The half that is not written keeps its value, and the merged value is compared again at once. The comparison runs continuously and its result is registered.

Top module: `core_timer_intc`

## Requirements
- R1: Hart h has its software-interrupt word at SWI_BASE + 4*h. A write there affects only that hart's software-interrupt output.
- R2: Bit 0 of the written data sets (1) or clears (0) the hart's software-interrupt output from the write's clock edge on. A read of the word returns the flag in bit 0, with bits 31:1 zero.
- R3: Hart h's compare register is at CMP_BASE + 8*h. Bits 31:0 are at byte offset 0 and bits 63:32 at byte offset 4. Both halves read back what was written (little-endian word order).
- R4: A write to one compare half keeps the other half unchanged.
- R5: A hart's timer-interrupt output is high exactly when its compare value is at most the current time, as an unsigned 64-bit comparison. It is updated on the clock edge after the inputs of the comparison change. A compare value already in the past asserts it, and a value in the future clears it, including one with bit 63 set.
- R6: When time advances to reach a stored compare value, the timer interrupt asserts with no register access.
- R7: The time counter resets to 0 and increments by one on each clock edge where tick_en is high. Its bits 31:0 read at TIME_BASE and its bits 63:32 at TIME_BASE + 4.
- R8: Writes to either time word leave the counter unchanged.
- R9: Reset clears every compare register, every software-interrupt flag and the read data. The timer interrupts are low during reset and high one edge after reset is released, because a compare value of 0 is not later than a time of 0.
- R10: Reads of unmapped addresses, and of an offset that is not word-aligned inside a software-interrupt slot or not at byte 0 or 4 of a compare slot, return 0. Writes to such addresses change no state.
- R11: Read data is registered. It is valid in the cycle after the read request and holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Timebase tick; the time counter advances on each cycle it is high |
| bus_en | input | 1 | Register request valid |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (16) | Byte address within the block |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle after a read |
| swi_o | output | HARTS (4) | Per-hart software-interrupt lines |
| tmr_o | output | HARTS (4) | Per-hart timer-interrupt lines |

## Verification
The bench looks for a half write that drops the retained half. Such a design would read back a zero high word and would compare against the wrong value. It sets a compare value with bit 63 high, which a signed comparator would treat as already past and so fire at once. It lets time tick up to a compare value one step at a time, so a strict less-than or an off-by-one timing shows up as a missing or early interrupt. It also writes to the time words, to misaligned slot offsets and to unmapped space, where a loose decoder would alias onto a real register, and it adds random half writes checked against a model of the compare registers.

// File: rtl/ctim_pkg.sv
// ctim_pkg: types and constants shared by the core-local timer interruptor.
// Assumes: the time counter and compare registers are 64 bits and the
// register port is 32 bits wide.
package ctim_pkg;

    localparam int TIME_W = 64;
    localparam int WORD_W = 32;

    // Register region picked by the address decoder.
    typedef enum logic [2:0] {
        RGN_NONE    = 3'd0,
        RGN_SWI     = 3'd1,
        RGN_CMP_LO  = 3'd2,
        RGN_CMP_HI  = 3'd3,
        RGN_TIME_LO = 3'd4,
        RGN_TIME_HI = 3'd5
    } region_e;

endpackage

// File: rtl/ctim_decode.sv
// ctim_decode: turns a byte address into a register region and a hart index.
// Assumes: the three regions do not overlap. Where they do, the
// software-interrupt region wins over the compare region, which wins over
// the time words. Misaligned slot offsets decode to RGN_NONE.
module ctim_decode #(
    parameter int ADDR_W    = 16,
    parameter int HARTS     = 4,
    parameter int SWI_BASE  = 'h0000,
    parameter int CMP_BASE  = 'h4000,
    parameter int TIME_BASE = 'hBFF8,
    localparam int HIDX_W   = (HARTS > 1) ? $clog2(HARTS) : 1
) (
    input  logic [ADDR_W-1:0]  addr,
    output ctim_pkg::region_e  region,
    output logic [HIDX_W-1:0]  hart
);
    import ctim_pkg::*;

    localparam logic [ADDR_W-1:0] SWI_B    = ADDR_W'(SWI_BASE);
    localparam logic [ADDR_W-1:0] CMP_B    = ADDR_W'(CMP_BASE);
    localparam logic [ADDR_W-1:0] TIME_B   = ADDR_W'(TIME_BASE);
    localparam logic [ADDR_W-1:0] TIME_B4  = ADDR_W'(TIME_BASE + 4);
    localparam logic [ADDR_W-1:0] SWI_SPAN = ADDR_W'(4 * HARTS);
    localparam logic [ADDR_W-1:0] CMP_SPAN = ADDR_W'(8 * HARTS);

    logic [ADDR_W-1:0] swi_off;
    logic [ADDR_W-1:0] cmp_off;
    logic              swi_hit;
    logic              cmp_hit;

    // Offsets from each region base and the range tests.
    always_comb begin
        swi_off = addr - SWI_B;
        cmp_off = addr - CMP_B;
        swi_hit = (addr >= SWI_B) && (swi_off < SWI_SPAN);
        cmp_hit = (addr >= CMP_B) && (cmp_off < CMP_SPAN);
    end

    // Region selection with alignment rules and hart index extraction.
    always_comb begin
        region = RGN_NONE;
        hart   = '0;
        if (swi_hit) begin
            hart = swi_off[HIDX_W+1:2];
            if (swi_off[1:0] == 2'b00) region = RGN_SWI;
        end else if (cmp_hit) begin
            hart = cmp_off[HIDX_W+2:3];
            if (cmp_off[2:0] == 3'd0)      region = RGN_CMP_LO;
            else if (cmp_off[2:0] == 3'd4) region = RGN_CMP_HI;
        end else if (addr == TIME_B) begin
            region = RGN_TIME_LO;
        end else if (addr == TIME_B4) begin
            region = RGN_TIME_HI;
        end
    end

endmodule

// File: rtl/ctim_timebase.sv
// ctim_timebase: the shared free-running 64-bit time counter.
// Assumes: tick_en is already synchronous to clk. There is no write path,
// so software can only read the counter.
module ctim_timebase (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          tick_en,
    output logic [ctim_pkg::TIME_W-1:0]   now
);
    import ctim_pkg::*;

    logic [TIME_W-1:0] now_q;

    // Count one step per enabled tick; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       now_q <= '0;
        else if (tick_en) now_q <= now_q + TIME_W'(1);
    end

    assign now = now_q;

    AST_TIME_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        tick_en |=> now == $past(now) + TIME_W'(1)); // R7
    AST_TIME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(now)); // R8

endmodule

// File: rtl/ctim_hart_slot.sv
// ctim_hart_slot: the per-hart state, which is the software-interrupt flag,
// the 64-bit compare register and the registered timer-interrupt line.
// Assumes: at most one of the three write strobes is high in any cycle, as
// guaranteed by the decoder.
module ctim_hart_slot (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          swi_wr,
    input  logic                          cmp_lo_wr,
    input  logic                          cmp_hi_wr,
    input  logic [ctim_pkg::WORD_W-1:0]   wdata,
    input  logic [ctim_pkg::TIME_W-1:0]   now,
    output logic                          swi_o,
    output logic                          tmr_o,
    output logic [ctim_pkg::TIME_W-1:0]   cmp_o
);
    import ctim_pkg::*;

    logic              swi_q;
    logic [TIME_W-1:0] cmp_q;
    logic [TIME_W-1:0] cmp_d;
    logic              tmr_q;
    logic              due;

    // Software-interrupt flag follows bit 0 of each write to its word.
    always_ff @(posedge clk) begin
        if (!rst_n)      swi_q <= 1'b0;
        else if (swi_wr) swi_q <= wdata[0];
    end

    // Merge the written half with the half that is kept.
    always_comb begin
        cmp_d = cmp_q;
        if (cmp_lo_wr) cmp_d[WORD_W-1:0]      = wdata;
        if (cmp_hi_wr) cmp_d[TIME_W-1:WORD_W] = wdata;
    end

    // Compare register storage.
    always_ff @(posedge clk) begin
        if (!rst_n) cmp_q <= '0;
        else        cmp_q <= cmp_d;
    end

    // Unsigned "deadline reached" test against the current time.
    assign due = (cmp_q <= now);

    // Register the comparison so the interrupt line is glitch-free.
    always_ff @(posedge clk) begin
        if (!rst_n) tmr_q <= 1'b0;
        else        tmr_q <= due;
    end

    assign swi_o = swi_q;
    assign tmr_o = tmr_q;
    assign cmp_o = cmp_q;

    AST_SWI_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        swi_wr |=> swi_o == $past(wdata[0])); // R2
    AST_LO_KEEPS_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_lo_wr && !cmp_hi_wr) |=> cmp_o[63:32] == $past(cmp_o[63:32])); // R4
    AST_HI_KEEPS_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_hi_wr && !cmp_lo_wr) |=> cmp_o[31:0] == $past(cmp_o[31:0])); // R4
    AST_CMP_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmp_lo_wr && !cmp_hi_wr) |=> $stable(cmp_o)); // R10
    AST_TMR_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmr_o) |-> $past(cmp_o <= now)); // R5
    AST_TMR_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tmr_o) |-> $past(cmp_o > now)); // R5

endmodule

// File: rtl/core_timer_intc.sv
// core_timer_intc: top of the core-local timer interruptor. It decodes the
// 32-bit register port, routes writes to the per-hart slots and returns
// registered read data from the slots and the time counter.
// Assumes: one request per cycle, with no back-pressure and no error
// response. Region bases are byte offsets inside an ADDR_W-bit space.
module core_timer_intc #(
    parameter int ADDR_W    = 16,
    parameter int HARTS     = 4,
    parameter int SWI_BASE  = 'h0000,
    parameter int CMP_BASE  = 'h4000,
    parameter int TIME_BASE = 'hBFF8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [HARTS-1:0]  swi_o,
    output logic [HARTS-1:0]  tmr_o
);
    import ctim_pkg::*;

    localparam int HIDX_W = (HARTS > 1) ? $clog2(HARTS) : 1;

    region_e            region;
    logic [HIDX_W-1:0]  hidx;
    logic [TIME_W-1:0]  now;
    logic [TIME_W-1:0]  cmp_all [HARTS];
    logic [WORD_W-1:0]  rd_mux;
    logic [WORD_W-1:0]  rdata_q;
    logic               wr_req;
    logic               rd_req;

    assign wr_req = bus_en && bus_we;
    assign rd_req = bus_en && !bus_we;

    ctim_decode #(
        .ADDR_W(ADDR_W), .HARTS(HARTS), .SWI_BASE(SWI_BASE),
        .CMP_BASE(CMP_BASE), .TIME_BASE(TIME_BASE)
    ) u_decode (
        .addr(bus_addr), .region(region), .hart(hidx)
    );

    ctim_timebase u_timebase (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .now(now)
    );

    // One slot per hart, each with write strobes qualified by its index.
    for (genvar h = 0; h < HARTS; h++) begin : g_slot
        logic sel;
        assign sel = wr_req && (hidx == HIDX_W'(h));
        ctim_hart_slot u_slot (
            .clk(clk), .rst_n(rst_n),
            .swi_wr(sel && (region == RGN_SWI)),
            .cmp_lo_wr(sel && (region == RGN_CMP_LO)),
            .cmp_hi_wr(sel && (region == RGN_CMP_HI)),
            .wdata(bus_wdata), .now(now),
            .swi_o(swi_o[h]), .tmr_o(tmr_o[h]), .cmp_o(cmp_all[h])
        );
    end

    // Read multiplexer; unmatched regions read as zero.
    always_comb begin
        rd_mux = '0;
        case (region)
            RGN_SWI:     rd_mux = {31'd0, swi_o[hidx]};
            RGN_CMP_LO:  rd_mux = cmp_all[hidx][WORD_W-1:0];
            RGN_CMP_HI:  rd_mux = cmp_all[hidx][TIME_W-1:WORD_W];
            RGN_TIME_LO: rd_mux = now[WORD_W-1:0];
            RGN_TIME_HI: rd_mux = now[TIME_W-1:WORD_W];
            default:     rd_mux = '0;
        endcase
    end

    // Capture read data one cycle after the request; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)      rdata_q <= '0;
        else if (rd_req) rdata_q <= rd_mux;
    end

    assign bus_rdata = rdata_q;

    AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && region == RGN_NONE) |=> bus_rdata == 32'd0); // R10
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> $stable(bus_rdata)); // R11
    AST_SWI_READ_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && region == RGN_SWI) |=> bus_rdata[31:1] == 31'd0); // R2
    AST_TIME_READ_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && region == RGN_TIME_LO) |=> bus_rdata == $past(now[31:0])); // R7

endmodule

// File: tb/tb_core_timer_intc.sv
// tb_core_timer_intc: directed corner cases plus seeded random compare
// writes, checked against a bench-side model of time, compare and flags.
module tb_core_timer_intc;

    localparam int HARTS = 4;
    localparam logic [15:0] SWI_B  = 16'h0000;
    localparam logic [15:0] CMP_B  = 16'h4000;
    localparam logic [15:0] TIME_B = 16'hBFF8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [HARTS-1:0] swi_o;
    logic [HARTS-1:0] tmr_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [63:0] m_time = 64'd0;
    logic [63:0] m_cmp [HARTS];
    logic [HARTS-1:0] m_swi = '0;

    core_timer_intc dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_en(bus_en),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .swi_o(swi_o), .tmr_o(tmr_o)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(posedge clk); @(negedge clk); end
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [31:0] d);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(posedge clk); @(negedge clk);
        bus_en = 1'b0;
        d = bus_rdata;
    endtask

    task automatic tick(input int n);
        tick_en = 1'b1;
        repeat (n) @(posedge clk);
        @(negedge clk);
        tick_en = 1'b0;
        m_time = m_time + 64'(n);
    endtask

    function automatic logic [15:0] cmp_addr(input int h, input bit hi);
        return CMP_B + 16'(8 * h) + (hi ? 16'd4 : 16'd0);
    endfunction

    function automatic logic [HARTS-1:0] exp_tmr();
        logic [HARTS-1:0] r;
        for (int h = 0; h < HARTS; h++) r[h] = (m_cmp[h] <= m_time);
        return r;
    endfunction

    task automatic wr_cmp(input int h, input bit hi, input logic [31:0] d);
        wr(cmp_addr(h, hi), d);
        if (hi) m_cmp[h][63:32] = d; else m_cmp[h][31:0] = d;
    endtask

    // Read back both halves of hart h's compare register against the model.
    task automatic chk_cmp(input string tag, input int h);
        logic [31:0] lo, hi;
        rd(cmp_addr(h, 1'b0), lo);
        rd(cmp_addr(h, 1'b1), hi);
        chk(tag, {hi, lo}, m_cmp[h]);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        for (int h = 0; h < HARTS; h++) m_cmp[h] = 64'd0;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R9: state during reset
        chk("R9 swi in reset", 64'(swi_o), 64'd0);
        chk("R9 tmr in reset", 64'(tmr_o), 64'd0);
        chk("R9 rdata in reset", 64'(bus_rdata), 64'd0);
        rst_n = 1'b1;
        idle(1);
        chk("R9 tmr after reset", 64'(tmr_o), 64'hF);
        rd(cmp_addr(3, 1'b1), d);
        chk("R9 cmp reset hi", 64'(d), 64'd0);

        // R7: time counts ticks
        tick(100);
        rd(TIME_B, d);
        chk("R7 time lo", 64'(d), 64'd100);
        chk("R11 read data after one edge", 64'(bus_rdata), 64'd100);
        rd(TIME_B + 16'd4, d);
        chk("R7 time hi", 64'(d), 64'd0);
        // R8: time writes ignored
        wr(TIME_B, 32'h1234);
        wr(TIME_B + 16'd4, 32'h55);
        rd(TIME_B, d);
        chk("R8 time lo after write", 64'(d), 64'd100);
        rd(TIME_B + 16'd4, d);
        chk("R8 time hi after write", 64'(d), 64'd0);
        // R11: read data holds over a write
        wr(SWI_B, 32'd0);
        chk("R11 rdata holds", 64'(bus_rdata), 64'd0);

        // R1/R2: software interrupts
        for (int h = 0; h < HARTS; h++) begin
            wr(SWI_B + 16'(4 * h), 32'd1);
            chk("R1 swi one hart", 64'(swi_o), 64'(1 << h));
            wr(SWI_B + 16'(4 * h), 32'hFFFF_FFFE);
            chk("R2 swi clear", 64'(swi_o), 64'd0);
        end
        wr(SWI_B + 16'd8, 32'h3);
        rd(SWI_B + 16'd8, d);
        chk("R2 swi read bit0 only", 64'(d), 64'd1);
        // R10: misaligned software-interrupt offset
        wr(SWI_B + 16'd5, 32'd1);
        chk("R10 misaligned swi write", 64'(swi_o), 64'h4);
        rd(SWI_B + 16'd5, d);
        chk("R10 misaligned swi read", 64'(d), 64'd0);
        wr(SWI_B + 16'd8, 32'd0);

        // R3/R4/R5: compare halves
        wr_cmp(1, 1'b0, 32'hDEAD_0000);
        wr_cmp(1, 1'b1, 32'h1);
        chk_cmp("R3 cmp readback", 1);
        wr_cmp(1, 1'b0, 32'd5);
        chk_cmp("R4 lo write keeps hi", 1);
        chk("R5 future clears", 64'(tmr_o), 64'(exp_tmr()));
        wr_cmp(1, 1'b1, 32'd0);
        chk_cmp("R4 hi write keeps lo", 1);
        idle(1);
        chk("R5 past fires", 64'(tmr_o), 64'(exp_tmr()));
        wr_cmp(2, 1'b1, 32'h8000_0000);
        idle(1);
        chk("R5 bit63 is future", 64'(tmr_o[2]), 64'd0);

        // R6: time reaches compare
        wr_cmp(0, 1'b0, 32'(m_time + 64'd7));
        idle(1);
        chk("R6 before reach", 64'(tmr_o[0]), 64'd0);
        tick(6);
        idle(1);
        chk("R6 one short", 64'(tmr_o[0]), 64'd0);
        tick(1);
        idle(1);
        chk("R6 reached", 64'(tmr_o[0]), 64'd1);

        // R10: misaligned compare and unmapped accesses
        wr(CMP_B + 16'd2, 32'hFFFF_FFFF);
        wr(16'h8000, 32'hFFFF_FFFF);
        chk_cmp("R10 misaligned cmp write", 0);
        rd(CMP_B + 16'd2, d);
        chk("R10 misaligned cmp read", 64'(d), 64'd0);
        rd(16'h8000, d);
        chk("R10 unmapped read", 64'(d), 64'd0);
        idle(1);
        chk("R10 unmapped write no irq change", 64'(tmr_o), 64'(exp_tmr()));

        // R4/R5: random half writes around the current time
        for (int i = 0; i < 300; i++) begin
            int h;
            bit hi;
            logic [31:0] v;
            h  = int'($urandom_range(HARTS - 1));
            hi = 1'($urandom_range(1));
            if (hi) v = ($urandom_range(3) == 0) ? $urandom() : 32'd0;
            else    v = 32'(m_time) - 32'd40 + 32'($urandom_range(80));
            wr_cmp(h, hi, v);
            if ($urandom_range(3) == 0) tick(int'($urandom_range(20)) + 1);
            idle(1);
            chk("R5 random irq", 64'(tmr_o), 64'(exp_tmr()));
            if (i % 10 == 0) chk_cmp("R4 random readback", h);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule